// File: doc/BRIEF.md
# Two-Section Decade Counter with Preset to Nine

The block is a 4-bit counter made of two sections, each with its own count input. A divide-by-two section toggles output bit 0. A divide-by-five section steps output bits 3..1 through the values 0 to 4 and then wraps to 0. Each section advances on a falling edge of its count input. Both count inputs are sampled by a free-running system clock. A falling edge becomes a one-cycle enable, so every register in the block is clocked by the system clock.

Two gated controls act on both sections. Clear needs both of its inputs high and drives all four outputs low. Preset needs both of its inputs high, drives the outputs to nine (binary 1001) and overrides clear. Both controls reach the outputs at once, without waiting for a clock edge. Their release is re-timed to the system clock, and counting resumes from the forced value.

The user makes the connection between the sections outside the block. Feeding output bit 0 into the divide-by-five count input gives a BCD counter. Feeding output bit 3 into the divide-by-two count input, with counts applied to the divide-by-five input, gives a symmetrical divide-by-ten square wave on output bit 0.

Top module: `tenstep_counter`

## Requirements
- R1: Output bit 0 toggles once for each falling edge on `tick_a`. A falling edge is a sample high followed by a sample low. The new value appears within four system clocks of the edge. A rising edge has no effect.
- R2: Output bits 3..1 step through 000, 001, 010, 011, 100 and back to 000, one step for each falling edge on `tick_b`. The new value appears within four system clocks of the edge.
- R3: While `clr_a` and `clr_b` are both high and the preset is not active, `q` reads 0 immediately. Count edges on either input are ignored during that time.
- R4: With only one of `clr_a` and `clr_b` high, the count is not changed.
- R5: While `nine_a` and `nine_b` are both high, `q` reads 9 (bits 3 and 0 set). This holds whatever the clear inputs are doing.
- R6: With only one of `nine_a` and `nine_b` high, the count is not changed.
- R7: After clear or preset is released, the forced value stays in the counter. The next count edge that arrives two or more system clocks after the release advances from that value.
- R8: With `q[0]` fed back to `tick_b` and counts applied to `tick_a`, `q` follows 0,1,...,9 and then returns to 0.
- R9: With `q[3]` fed back to `tick_a` and counts applied to `tick_b`, `q[0]` changes state exactly once every five count edges.
- R10: While `rst_n` is low, `q` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count input of the divide-by-two section, active on a falling edge |
| tick_b | input | 1 | Count input of the divide-by-five section, active on a falling edge |
| clr_a | input | 1 | Clear gate input, first of two |
| clr_b | input | 1 | Clear gate input, second of two |
| nine_a | input | 1 | Preset-to-nine gate input, first of two |
| nine_b | input | 1 | Preset-to-nine gate input, second of two |
| q | output | 4 | Count value: bit 0 from the divide-by-two section, bits 3..1 from the divide-by-five section |

## Verification
The bench targets the wrap of the divide-by-five section from 4 to 0. A design that got this wrong would count past 4 and break both the BCD sequence and the divide-by-ten output. It also targets the gated controls with only one input high, which a design wired as OR instead of AND would wrongly obey. Preset is asserted together with clear, to catch a design that lets clear win. The bench checks the value left after release, to catch a design that snaps back to the old count. In BCD mode the bench checks the carry from 9 to 0 through the fed-back bit. A lost or doubled carry would show up there as a skipped or repeated decade value.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned LOW_W   = 1;
  localparam int unsigned HIGH_W  = 3;
  localparam int unsigned Q_W     = LOW_W + HIGH_W;
  localparam int unsigned HIGH_MOD = 5;
  localparam logic [Q_W-1:0] PRESET_VAL = 4'd9;

  // next state of the divide-by-five section; unused codes fall back to 0
  function automatic logic [HIGH_W-1:0] next_high(input logic [HIGH_W-1:0] cur);
    if (cur >= HIGH_W'(HIGH_MOD - 1)) next_high = '0;
    else                              next_high = cur + HIGH_W'(1);
  endfunction
endpackage

// File: rtl/tsc_fall_detect.sv
module tsc_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tsc_release_sync.sv
module tsc_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arm_n,
  output logic hold_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arm_n) begin
    if (!arm_n) shift_q <= '1;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b0};
  end

  assign hold_o = shift_q[STAGES-1];
endmodule

// File: rtl/tsc_section.sv
module tsc_section #(
  parameter int unsigned W      = 1,
  parameter int unsigned MOD    = 2,
  parameter logic [W-1:0] SET_V = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         force_set,
  input  logic         force_clr,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic [W-1:0] step_v;

  generate
    if (MOD == 2) begin : g_toggle
      assign step_v = ~val_q;
    end else begin : g_mod
      assign step_v = (val_q >= W'(MOD - 1)) ? '0 : val_q + W'(1);
    end
  endgenerate

  always_comb begin
    val_d = val_q;
    if (force_set)      val_d = SET_V;
    else if (force_clr) val_d = '0;
    else if (step_en)   val_d = step_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/tenstep_counter.sv
module tenstep_counter
  import tsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RLS_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_a,
  input  logic           tick_b,
  input  logic           clr_a,
  input  logic           clr_b,
  input  logic           nine_a,
  input  logic           nine_b,
  output logic [Q_W-1:0] q
);
  localparam int unsigned NUM_TICKS = 2;

  logic [NUM_TICKS-1:0] tick_raw;
  logic [NUM_TICKS-1:0] tick_fall;
  logic                 clr_req;
  logic                 set_req;
  logic                 hold_clr;
  logic                 hold_set;
  logic [LOW_W-1:0]     cnt_low;
  logic [HIGH_W-1:0]    cnt_high;
  logic [Q_W-1:0]       cnt_all;

  assign tick_raw = {tick_b, tick_a};
  assign clr_req  = clr_a & clr_b;
  assign set_req  = nine_a & nine_b;

  generate
    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_tick
      tsc_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (tick_raw[g]),
        .fall_o (tick_fall[g])
      );
    end
  endgenerate

  tsc_release_sync #(.STAGES(RLS_STAGES)) u_clr_sync (
    .clk    (clk),
    .arm_n  (rst_n & ~clr_req),
    .hold_o (hold_clr)
  );

  tsc_release_sync #(.STAGES(RLS_STAGES)) u_set_sync (
    .clk    (clk),
    .arm_n  (~set_req),
    .hold_o (hold_set)
  );

  tsc_section #(.W(LOW_W), .MOD(2), .SET_V(PRESET_VAL[LOW_W-1:0])) u_low (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (tick_fall[0]),
    .force_set (hold_set),
    .force_clr (hold_clr),
    .val_o     (cnt_low)
  );

  tsc_section #(.W(HIGH_W), .MOD(HIGH_MOD), .SET_V(PRESET_VAL[Q_W-1:LOW_W])) u_high (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (tick_fall[1]),
    .force_set (hold_set),
    .force_clr (hold_clr),
    .val_o     (cnt_high)
  );

  assign cnt_all = {cnt_high, cnt_low};

  always_comb begin
    if (set_req | hold_set)      q = PRESET_VAL;
    else if (clr_req | hold_clr) q = '0;
    else                         q = cnt_all;
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [Q_W-1:0]    q,
  input logic [LOW_W-1:0]  cnt_low,
  input logic [HIGH_W-1:0] cnt_high,
  input logic [1:0]        tick_fall,
  input logic              hold_set,
  input logic              hold_clr,
  input logic              clr_req,
  input logic              set_req
);
  // R1: a strobe on the low section flips it when no force is held
  a_r1_low_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_fall[0]) && !$past(hold_set) && !$past(hold_clr)) |-> (cnt_low != $past(cnt_low)));

  // R2: a strobe on the high section takes the next value of the five-step sequence
  a_r2_high_steps: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_fall[1]) && !$past(hold_set) && !$past(hold_clr)) |-> (cnt_high == next_high($past(cnt_high))));

  // R2: without a strobe or force the high section holds still
  a_r2_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_fall[1] && !hold_set && !hold_clr) |=> $stable(cnt_high));

  // R2: output bits 3..1 never leave the range 0..4
  a_r2_high_range: assert property (@(posedge clk) disable iff (!rst_n)
    q[Q_W-1:LOW_W] <= HIGH_W'(HIGH_MOD - 1));

  // R3: gated clear without preset shows zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |-> (q == '0));

  // R5: gated preset shows nine regardless of clear
  a_r5_preset_nine: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |-> (q == PRESET_VAL));
endmodule

bind tenstep_counter tsc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .q         (q),
  .cnt_low   (cnt_low),
  .cnt_high  (cnt_high),
  .tick_fall (tick_fall),
  .hold_set  (hold_set),
  .hold_clr  (hold_clr),
  .clr_req   (clr_req),
  .set_req   (set_req)
);

// File: tb/tenstep_counter_test.sv
module tenstep_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv_a = 1'b0;
  logic       drv_b = 1'b0;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic       nine_a = 1'b0;
  logic       nine_b = 1'b0;
  logic [1:0] link = 2'd0;  // 0 free, 1 BCD (q0->tick_b), 2 bi-quinary (q3->tick_a)
  logic [3:0] q;
  logic       tick_a;
  logic       tick_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_low = 0;
  int m_high = 0;

  assign tick_a = (link == 2'd2) ? q[3] : drv_a;
  assign tick_b = (link == 2'd1) ? q[0] : drv_b;

  always #2 clk = ~clk;

  tenstep_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q(q)
  );

  function automatic int step5(input int v);
    return (v >= 4) ? 0 : v + 1;
  endfunction

  function automatic logic [3:0] model_q();
    return 4'((m_high << 1) | m_low);
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one count edge on the A input; model follows the BCD carry when linked
  task automatic pulse_a();
    drv_a = 1'b1; idle(10);
    drv_a = 1'b0; idle(10);
    m_low = 1 - m_low;
    if (link == 2'd1 && m_low == 0) m_high = step5(m_high);
  endtask

  task automatic pulse_b();
    drv_b = 1'b1; idle(10);
    drv_b = 1'b0; idle(10);
    if (m_high == 4 && link == 2'd2) m_low = 1 - m_low;
    m_high = step5(m_high);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int pick;
    seed = $urandom(32'h5eed_0a1b);
    idle(6);
    chk("R10 reset", q, 4'd0);
    rst_n = 1'b1;
    idle(4);
    chk("R10 after release", q, 4'd0);

    // R1: low section toggles, rising edge alone does nothing
    drv_a = 1'b1; idle(10);
    chk("R1 rising ignored", q, model_q());
    drv_a = 1'b0; idle(10); m_low = 1;
    chk("R1 toggle", q, model_q());
    for (int i = 0; i < 3; i++) begin pulse_a(); chk("R1 toggle", q, model_q()); end

    // R2: high section five-step sequence with wrap
    for (int i = 0; i < 7; i++) begin pulse_b(); chk("R2 step", q, model_q()); end

    // R4: a single clear input has no effect
    clr_a = 1'b1; idle(8); chk("R4 clr_a alone", q, model_q());
    clr_a = 1'b0; clr_b = 1'b1; idle(8); chk("R4 clr_b alone", q, model_q());
    clr_b = 1'b0; idle(4);

    // R3: clear shows zero at once and overrides count edges
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1; #1;
    chk("R3 immediate", q, 4'd0);
    pulse_a(); pulse_b();
    chk("R3 counts ignored", q, 4'd0);
    clr_a = 1'b0; clr_b = 1'b0; idle(6);
    m_low = 0; m_high = 0;
    chk("R7 zero kept", q, 4'd0);
    pulse_b(); chk("R7 resume from zero", q, model_q());

    // R6: a single preset input has no effect
    nine_a = 1'b1; idle(8); chk("R6 nine_a alone", q, model_q());
    nine_a = 1'b0; nine_b = 1'b1; idle(8); chk("R6 nine_b alone", q, model_q());
    nine_b = 1'b0; idle(4);

    // R5: preset wins over clear
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1; nine_a = 1'b1; nine_b = 1'b1; #1;
    chk("R5 preset over clear", q, 4'd9);
    idle(6);
    nine_a = 1'b0; nine_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0; idle(6);
    m_low = 1; m_high = 4;
    chk("R7 nine kept", q, 4'd9);

    // R8: BCD with q0 fed to tick_b; from nine the next count wraps to zero
    link = 2'd1; idle(10);
    for (int i = 0; i < 12; i++) begin pulse_a(); chk("R8 bcd", q, model_q()); end
    link = 2'd0; idle(10);

    // R9: bi-quinary, q0 flips every five counts
    clr_a = 1'b1; clr_b = 1'b1; idle(4); clr_a = 1'b0; clr_b = 1'b0; idle(6);
    m_low = 0; m_high = 0;
    link = 2'd2; idle(10);
    for (int i = 1; i <= 20; i++) begin
      pulse_b();
      chk("R9 biquinary", q, model_q());
      if (i % 5 == 0) chk("R9 q0 period", {3'b0, q[0]}, 4'((i / 5) % 2));
    end
    link = 2'd0; idle(10);

    // random mix in free mode
    for (int i = 0; i < 80; i++) begin
      pick = $urandom_range(0, 9);
      if (pick < 4) begin
        pulse_a(); chk("R1 random", q, model_q());
      end else if (pick < 8) begin
        pulse_b(); chk("R2 random", q, model_q());
      end else if (pick == 8) begin
        clr_a = 1'b1; clr_b = 1'b1; idle(4); clr_a = 1'b0; clr_b = 1'b0; idle(6);
        m_low = 0; m_high = 0; chk("R3 random clear", q, 4'd0);
      end else begin
        nine_a = 1'b1; nine_b = 1'b1; idle(4); nine_a = 1'b0; nine_b = 1'b0; idle(6);
        m_low = 1; m_high = 4; chk("R5 random preset", q, 4'd9);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule